// File: doc/BRIEF.md
# Pipelined Delay-and-Sum Voxel Engine

This block computes how one ultrasonic A-scan contributes to every point of a cubic 3D imaging grid. It uses time-domain delay and sum. A host first writes the A-scan samples into a local buffer through a write port. It then sets the run parameters on the parameter inputs: the lateral scan position, the three grid steps, a delay scale that folds together the round-trip factor, the inverse sound speed and the sampling rate, and the number of valid samples. Finally it pulses `start`.

The engine then walks the whole grid. It uses a parameterised number of lanes, and each lane accepts one voxel per clock. Every lane carries a fully pipelined datapath: coordinate offsets, sum of squares, a bit-serial square root unrolled into one stage per result bit, delay scaling with rounding, and a sample fetch from that lane's own copy of the buffer. Each lane emits a valid/ready stream of voxel address and signed amplitude. A `done` pulse follows the last accepted result. Summing the results of many A-scans is left to the consumer.

Top module: `voxel_das_engine`

## Requirements
- R1: Each accepted start produces exactly one result for every voxel of the G×G×G grid (G = 2^GBITS). The address of a voxel is (x·G + y)·G + z, so z varies fastest.
- R2: The amplitude of a voxel is sample[k], where d = floor(sqrt((x·stepX − scanX)² + (y·stepY − scanY)² + (z·stepZ)²)) and k = (d·delayScale + 2^(FRAC−1)) >> FRAC. Here delayScale is unsigned with FRAC fraction bits (FRAC = 8 by default), scanX and scanY are two's complement, and the steps are unsigned. sample[a] is the last value written with wrEn high at wrAddr = a.
- R3: When k ≥ sampleCount, the amplitude is 0. This includes sampleCount = 0.
- R4: Lane j (0-based) emits only addresses whose value modulo LANES is j.
- R5: While a lane holds outValid high and its outReady is low, the lane keeps outValid, outAddr and outAmp unchanged. Backpressure neither loses nor repeats a result.
- R6: done is high for exactly one cycle per accepted start. It comes after the last result of the run has been accepted, and no result follows it.
- R7: With every outReady held high, done arrives no more than G³/LANES + ROOT_W + 8 cycles after start, where ROOT_W = GBITS + STEP_W + 3. It arrives no sooner than G³/LANES cycles after start.
- R8: A start raised while a run is in progress is ignored. The parameters are captured at the accepted start, so changing them during the run has no effect on its results.
- R9: A synchronous reset clears every output valid and done, and abandons any run in flight. No result and no done appear afterwards until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sweep; ignored while one is running |
| scanX | input | POS_W | Signed lateral scan position, x axis |
| scanY | input | POS_W | Signed lateral scan position, y axis |
| stepX | input | STEP_W | Grid step along x |
| stepY | input | STEP_W | Grid step along y |
| stepZ | input | STEP_W | Grid step along depth |
| delayScale | input | SCALE_W | Distance-to-sample scale, FRAC fraction bits |
| sampleCount | input | ABITS+1 | Number of valid samples |
| wrEn | input | 1 | Sample buffer write enable |
| wrAddr | input | ABITS | Sample buffer write address |
| wrData | input | AMP_W | Signed sample written |
| outValid | output | LANES | Per-lane result valid |
| outReady | input | LANES | Per-lane result ready |
| outAddr | output | LANES·3·GBITS | Per-lane voxel address, lane j at bits j·3·GBITS |
| outAmp | output | LANES·AMP_W | Per-lane signed amplitude |
| done | output | 1 | One-cycle pulse when the sweep has drained |

## Verification
The bench uses an 8×8×8 grid with two lanes. It compares every voxel against a square root and a rounding computed in the bench, so a root that is off by one, or a rounding constant that is missing, shows up as wrong amplitudes near sample-index boundaries. A run with a short sample count catches a design that reads past the valid samples instead of returning zero. A run that uses sampleCount = 0 catches an off-by-one in the range compare. A run under pseudo-random backpressure detects results that are dropped or duplicated when one lane stalls while another completes, and results that change while held. The same run raises start and rewrites the parameters in mid-sweep, which exposes a design that restarts or re-samples its parameters. A reset in mid-sweep shows whether stale pipeline contents leak out.

// File: rtl/das_pkg.sv
package das_pkg;
  typedef struct packed {
    logic loadParams;
    logic issue;
  } das_strobe_t;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_DRAIN} das_phase_t;
endpackage

// File: rtl/das_isqrt_pipe.sv
module das_isqrt_pipe #(
  parameter int SQ_W   = 32,
  parameter int SIDE_W = 15
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adv,
  input  logic                   inValid,
  input  logic [SIDE_W-1:0]      inSide,
  input  logic [SQ_W-1:0]        inRad,
  output logic                   outValid,
  output logic [SIDE_W-1:0]      outSide,
  output logic [SQ_W/2-1:0]      outRoot,
  output logic                   anyValid
);
  localparam int STAGES = SQ_W / 2;

  logic [SQ_W-1:0]   opR   [STAGES+1];
  logic [SQ_W-1:0]   resR  [STAGES+1];
  logic [SIDE_W-1:0] sideR [STAGES+1];
  logic [STAGES:0]   vR;
  logic [SQ_W-1:0]   opN   [STAGES];
  logic [SQ_W-1:0]   resN  [STAGES];

  assign opR[0]   = inRad;
  assign resR[0]  = '0;
  assign sideR[0] = inSide;
  assign vR[0]    = inValid;

  // one result bit is settled per stage
  always_comb begin
    for (int i = 0; i < STAGES; i++) begin
      logic [SQ_W-1:0] bitVal;
      logic [SQ_W-1:0] trial;
      bitVal = SQ_W'(1) << (SQ_W - 2 - 2 * i);
      trial  = resR[i] + bitVal;
      if (opR[i] >= trial) begin
        opN[i]  = opR[i] - trial;
        resN[i] = (resR[i] >> 1) + bitVal;
      end else begin
        opN[i]  = opR[i];
        resN[i] = resR[i] >> 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vR[STAGES:1] <= '0;
    end else if (adv) begin
      vR[STAGES:1] <= vR[STAGES-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int i = 0; i < STAGES; i++) begin
        opR[i+1]   <= opN[i];
        resR[i+1]  <= resN[i];
        sideR[i+1] <= sideR[i];
      end
    end
  end

  assign outValid = vR[STAGES];
  assign outSide  = sideR[STAGES];
  assign outRoot  = resR[STAGES][SQ_W/2-1:0];
  assign anyValid = |vR[STAGES:1];
endmodule

// File: rtl/das_lane.sv
module das_lane #(
  parameter int GBITS   = 5,
  parameter int LANES   = 4,
  parameter int LANE    = 0,
  parameter int STEP_W  = 8,
  parameter int POS_W   = 12,
  parameter int SCALE_W = 16,
  parameter int FRAC    = 8,
  parameter int ABITS   = 8,
  parameter int AMP_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic                    issue,
  input  logic [3*GBITS-1:0]      baseAddr,
  input  logic signed [POS_W-1:0] pScanX,
  input  logic signed [POS_W-1:0] pScanY,
  input  logic [STEP_W-1:0]       pStepX,
  input  logic [STEP_W-1:0]       pStepY,
  input  logic [STEP_W-1:0]       pStepZ,
  input  logic [SCALE_W-1:0]      pScale,
  input  logic [ABITS:0]          pCount,
  input  logic                    wrEn,
  input  logic [ABITS-1:0]        wrAddr,
  input  logic signed [AMP_W-1:0] wrData,
  input  logic                    outReady,
  output logic                    outValid,
  output logic [3*GBITS-1:0]      outAddr,
  output logic signed [AMP_W-1:0] outAmp,
  output logic                    laneBusy
);
  localparam int VB     = 3 * GBITS;
  localparam int LB     = $clog2(LANES);
  localparam int D_W    = GBITS + STEP_W + 2;
  localparam int SQ_W   = 2 * D_W + 2;
  localparam int ROOT_W = SQ_W / 2;
  localparam int IDX_W  = ROOT_W + SCALE_W + 1;
  localparam int DEPTH  = 1 << ABITS;
  localparam logic [IDX_W-1:0] HALF = IDX_W'(1) << (FRAC - 1);

  // replicated sample buffer, one read port per lane
  logic signed [AMP_W-1:0] sampleMem [DEPTH];
  always_ff @(posedge clk) begin
    if (wrEn) sampleMem[wrAddr] <= wrData;
  end

  // voxel coordinates of this lane's slot in the group
  logic [VB-1:0]    voxAddr;
  logic [GBITS-1:0] cx, cy, cz;
  assign voxAddr = baseAddr | VB'(LANE);
  assign cx = voxAddr[3*GBITS-1:2*GBITS];
  assign cy = voxAddr[2*GBITS-1:GBITS];
  assign cz = voxAddr[GBITS-1:0];

  // stage 1: signed offsets from the scan point
  logic [D_W-1:0] prodX, prodY, prodZ;
  logic signed [D_W-1:0] dxN, dyN;
  assign prodX = D_W'(cx) * D_W'(pStepX);
  assign prodY = D_W'(cy) * D_W'(pStepY);
  assign prodZ = D_W'(cz) * D_W'(pStepZ);
  assign dxN = $signed(prodX) - D_W'(pScanX);
  assign dyN = $signed(prodY) - D_W'(pScanY);

  logic                  s1Valid;
  logic [VB-1:0]         s1Addr;
  logic signed [D_W-1:0] s1Dx, s1Dy, s1Dz;
  always_ff @(posedge clk) begin
    if (rst) s1Valid <= 1'b0;
    else if (adv) s1Valid <= issue;
  end
  always_ff @(posedge clk) begin
    if (adv) begin
      s1Addr <= voxAddr;
      s1Dx   <= dxN;
      s1Dy   <= dyN;
      s1Dz   <= $signed(prodZ);
    end
  end

  // stage 2: squared distance
  logic signed [2*D_W-1:0] sqX, sqY, sqZ;
  assign sqX = s1Dx * s1Dx;
  assign sqY = s1Dy * s1Dy;
  assign sqZ = s1Dz * s1Dz;

  logic            s2Valid;
  logic [VB-1:0]   s2Addr;
  logic [SQ_W-1:0] s2Rad;
  always_ff @(posedge clk) begin
    if (rst) s2Valid <= 1'b0;
    else if (adv) s2Valid <= s1Valid;
  end
  always_ff @(posedge clk) begin
    if (adv) begin
      s2Addr <= s1Addr;
      s2Rad  <= SQ_W'($unsigned(sqX)) + SQ_W'($unsigned(sqY)) + SQ_W'($unsigned(sqZ));
    end
  end

  // stages 3..: bit-serial root
  logic              rtValid, rtBusy;
  logic [VB-1:0]     rtAddr;
  logic [ROOT_W-1:0] rtRoot;
  das_isqrt_pipe #(.SQ_W(SQ_W), .SIDE_W(VB)) uRoot (
    .clk(clk), .rst(rst), .adv(adv),
    .inValid(s2Valid), .inSide(s2Addr), .inRad(s2Rad),
    .outValid(rtValid), .outSide(rtAddr), .outRoot(rtRoot), .anyValid(rtBusy)
  );

  // delay scaling with rounding and range test
  logic [IDX_W-1:0] scaled, idxN;
  assign scaled = IDX_W'(rtRoot) * IDX_W'(pScale) + HALF;
  assign idxN   = scaled >> FRAC;

  logic             s3Valid, s3InRange;
  logic [VB-1:0]    s3Addr;
  logic [ABITS-1:0] s3Rd;
  always_ff @(posedge clk) begin
    if (rst) s3Valid <= 1'b0;
    else if (adv) s3Valid <= rtValid;
  end
  always_ff @(posedge clk) begin
    if (adv) begin
      s3Addr    <= rtAddr;
      s3InRange <= idxN < IDX_W'(pCount);
      s3Rd      <= idxN[ABITS-1:0];
    end
  end

  // output register with sample fetch
  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else if (adv) outValid <= s3Valid;
    else if (outReady) outValid <= 1'b0;
  end
  always_ff @(posedge clk) begin
    if (adv) begin
      outAddr <= s3Addr;
      outAmp  <= s3InRange ? sampleMem[s3Rd] : '0;
    end
  end

  assign laneBusy = s1Valid | s2Valid | rtBusy | rtValid | s3Valid | outValid;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outAmp)); // R5
  AST_LANE_RESIDUE: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outAddr[LB-1:0] == LB'(LANE)); // R4
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (rst)
    adv && s3Valid && !s3InRange |=> outAmp == '0); // R3
endmodule

// File: rtl/das_datapath.sv
module das_datapath
  import das_pkg::*;
#(
  parameter int GBITS   = 5,
  parameter int LANES   = 4,
  parameter int STEP_W  = 8,
  parameter int POS_W   = 12,
  parameter int SCALE_W = 16,
  parameter int FRAC    = 8,
  parameter int ABITS   = 8,
  parameter int AMP_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  das_strobe_t                 strobes,
  input  logic [3*GBITS-1:0]          baseAddr,
  input  logic signed [POS_W-1:0]     scanX,
  input  logic signed [POS_W-1:0]     scanY,
  input  logic [STEP_W-1:0]           stepX,
  input  logic [STEP_W-1:0]           stepY,
  input  logic [STEP_W-1:0]           stepZ,
  input  logic [SCALE_W-1:0]          delayScale,
  input  logic [ABITS:0]              sampleCount,
  input  logic                        wrEn,
  input  logic [ABITS-1:0]            wrAddr,
  input  logic signed [AMP_W-1:0]     wrData,
  input  logic [LANES-1:0]            outReady,
  output logic [LANES-1:0]            outValid,
  output logic [LANES*3*GBITS-1:0]    outAddr,
  output logic [LANES*AMP_W-1:0]      outAmp,
  output logic                        advance,
  output logic                        pipeEmpty
);
  localparam int VB = 3 * GBITS;

  // parameters captured at the accepted start
  logic signed [POS_W-1:0] pScanX, pScanY;
  logic [STEP_W-1:0]       pStepX, pStepY, pStepZ;
  logic [SCALE_W-1:0]      pScale;
  logic [ABITS:0]          pCount;
  always_ff @(posedge clk) begin
    if (rst) begin
      pScanX <= '0; pScanY <= '0;
      pStepX <= '0; pStepY <= '0; pStepZ <= '0;
      pScale <= '0; pCount <= '0;
    end else if (strobes.loadParams) begin
      pScanX <= scanX;  pScanY <= scanY;
      pStepX <= stepX;  pStepY <= stepY;  pStepZ <= stepZ;
      pScale <= delayScale;
      pCount <= sampleCount;
    end
  end

  logic [LANES-1:0] laneBusy;
  assign advance   = &(~outValid | outReady);
  assign pipeEmpty = ~|laneBusy;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    das_lane #(
      .GBITS(GBITS), .LANES(LANES), .LANE(j), .STEP_W(STEP_W), .POS_W(POS_W),
      .SCALE_W(SCALE_W), .FRAC(FRAC), .ABITS(ABITS), .AMP_W(AMP_W)
    ) uLane (
      .clk(clk), .rst(rst), .adv(advance), .issue(strobes.issue), .baseAddr(baseAddr),
      .pScanX(pScanX), .pScanY(pScanY), .pStepX(pStepX), .pStepY(pStepY), .pStepZ(pStepZ),
      .pScale(pScale), .pCount(pCount),
      .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
      .outReady(outReady[j]), .outValid(outValid[j]),
      .outAddr(outAddr[j*VB +: VB]), .outAmp(outAmp[j*AMP_W +: AMP_W]),
      .laneBusy(laneBusy[j])
    );
  end
endmodule

// File: rtl/das_ctrl.sv
module das_ctrl
  import das_pkg::*;
#(
  parameter int GBITS = 5,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               advance,
  input  logic               pipeEmpty,
  output das_strobe_t        strobes,
  output logic [3*GBITS-1:0] baseAddr,
  output logic               done
);
  localparam int VB = 3 * GBITS;
  localparam int LB = $clog2(LANES);

  das_phase_t phase;
  logic       lastGroup;
  assign lastGroup = &baseAddr[VB-1:LB];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      baseAddr <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          phase    <= PH_RUN;
          baseAddr <= '0;
        end
        PH_RUN: if (advance) begin
          if (lastGroup) phase <= PH_DRAIN;
          else baseAddr <= baseAddr + VB'(LANES);
        end
        PH_DRAIN: if (pipeEmpty) begin
          done  <= 1'b1;
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.loadParams = (phase == PH_IDLE) && start;
    strobes.issue      = (phase == PH_RUN);
  end

  AST_GROUP_STEP: assert property (@(posedge clk) disable iff (rst)
    phase == PH_RUN && advance && !lastGroup |=> baseAddr == $past(baseAddr) + VB'(LANES)); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    phase == PH_RUN && !advance |=> $stable(baseAddr) && phase == PH_RUN); // R5
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (rst)
    done |-> pipeEmpty); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
endmodule

// File: rtl/voxel_das_engine.sv
module voxel_das_engine
  import das_pkg::*;
#(
  parameter int GBITS   = 5,
  parameter int LANES   = 4,
  parameter int STEP_W  = 8,
  parameter int POS_W   = 12,
  parameter int SCALE_W = 16,
  parameter int FRAC    = 8,
  parameter int ABITS   = 8,
  parameter int AMP_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic signed [POS_W-1:0]  scanX,
  input  logic signed [POS_W-1:0]  scanY,
  input  logic [STEP_W-1:0]        stepX,
  input  logic [STEP_W-1:0]        stepY,
  input  logic [STEP_W-1:0]        stepZ,
  input  logic [SCALE_W-1:0]       delayScale,
  input  logic [ABITS:0]           sampleCount,
  input  logic                     wrEn,
  input  logic [ABITS-1:0]         wrAddr,
  input  logic signed [AMP_W-1:0]  wrData,
  output logic [LANES-1:0]         outValid,
  input  logic [LANES-1:0]         outReady,
  output logic [LANES*3*GBITS-1:0] outAddr,
  output logic [LANES*AMP_W-1:0]   outAmp,
  output logic                     done
);
  das_strobe_t        strobes;
  logic [3*GBITS-1:0] baseAddr;
  logic               advance, pipeEmpty;

  das_ctrl #(.GBITS(GBITS), .LANES(LANES)) uCtrl (
    .clk(clk), .rst(rst), .start(start), .advance(advance), .pipeEmpty(pipeEmpty),
    .strobes(strobes), .baseAddr(baseAddr), .done(done)
  );

  das_datapath #(
    .GBITS(GBITS), .LANES(LANES), .STEP_W(STEP_W), .POS_W(POS_W),
    .SCALE_W(SCALE_W), .FRAC(FRAC), .ABITS(ABITS), .AMP_W(AMP_W)
  ) uData (
    .clk(clk), .rst(rst), .strobes(strobes), .baseAddr(baseAddr),
    .scanX(scanX), .scanY(scanY), .stepX(stepX), .stepY(stepY), .stepZ(stepZ),
    .delayScale(delayScale), .sampleCount(sampleCount),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .outReady(outReady), .outValid(outValid), .outAddr(outAddr), .outAmp(outAmp),
    .advance(advance), .pipeEmpty(pipeEmpty)
  );
endmodule

// File: tb/voxel_das_engine_test.sv
module voxel_das_engine_test;
  localparam int PERIOD  = 10;
  localparam int GBITS   = 3;
  localparam int LANES   = 2;
  localparam int STEP_W  = 8;
  localparam int POS_W   = 12;
  localparam int SCALE_W = 16;
  localparam int FRAC    = 8;
  localparam int ABITS   = 6;
  localparam int AMP_W   = 16;
  localparam int G       = 1 << GBITS;
  localparam int NVOX    = G * G * G;
  localparam int VB      = 3 * GBITS;
  localparam int ROOT_W  = GBITS + STEP_W + 3;
  localparam int NS      = 1 << ABITS;

  logic clk = 0, rst = 1, start = 0;
  logic signed [POS_W-1:0] scanX = 0, scanY = 0;
  logic [STEP_W-1:0] stepX = 0, stepY = 0, stepZ = 0;
  logic [SCALE_W-1:0] delayScale = 0;
  logic [ABITS:0] sampleCount = 0;
  logic wrEn = 0;
  logic [ABITS-1:0] wrAddr = 0;
  logic signed [AMP_W-1:0] wrData = 0;
  logic [LANES-1:0] outValid, outReady;
  logic [LANES*VB-1:0] outAddr;
  logic [LANES*AMP_W-1:0] outAmp;
  logic done;

  int total = 0, bad = 0;
  int samp [NS];
  bit seen [NVOX];
  int eSx, eSy, eStX, eStY, eStZ, eScale, eCount;
  logic [7:0] lfsr = 8'hA5;

  initial outReady = '1;
  always #(PERIOD/2) clk = ~clk;

  voxel_das_engine #(
    .GBITS(GBITS), .LANES(LANES), .STEP_W(STEP_W), .POS_W(POS_W),
    .SCALE_W(SCALE_W), .FRAC(FRAC), .ABITS(ABITS), .AMP_W(AMP_W)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .scanX(scanX), .scanY(scanY),
    .stepX(stepX), .stepY(stepY), .stepZ(stepZ), .delayScale(delayScale),
    .sampleCount(sampleCount), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr), .outAmp(outAmp),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint isqrtRef(input longint n);
    longint r = 0;
    while ((r + 1) * (r + 1) <= n) r++;
    return r;
  endfunction

  function automatic int expAmp(input int addr);
    int x = addr / (G * G), y = (addr / G) % G, z = addr % G;
    longint dx = x * eStX - eSx, dy = y * eStY - eSy, dz = z * eStZ;
    longint d = isqrtRef(dx * dx + dy * dy + dz * dz);
    longint k = (d * eScale + (1 << (FRAC - 1))) >> FRAC;
    if (k >= eCount) return 0;
    return samp[k];
  endfunction

  task automatic loadSamples(input int seed);
    for (int i = 0; i < NS; i++) begin
      @(negedge clk);
      samp[i] = ((i * 73 + seed * 311) % 4001) - 2000;
      wrEn = 1; wrAddr = ABITS'(i); wrData = AMP_W'(samp[i]);
    end
    @(negedge clk);
    wrEn = 0;
  endtask

  // one sweep; backp = pseudo-random stalls, poke = extra start and parameter churn
  task automatic doRun(input string tag, input int sx, input int sy, input int tx,
                       input int ty, input int tz, input int sc, input int cnt,
                       input bit backp, input bit poke);
    int got = 0, dones = 0, cyc = 0, doneCyc = -1;
    int lastAddr [LANES];
    int lastAmp [LANES];
    bit held [LANES];
    for (int i = 0; i < NVOX; i++) seen[i] = 0;
    for (int j = 0; j < LANES; j++) held[j] = 0;
    eSx = sx; eSy = sy; eStX = tx; eStY = ty; eStZ = tz; eScale = sc; eCount = cnt;
    @(negedge clk);
    scanX = POS_W'(sx); scanY = POS_W'(sy);
    stepX = STEP_W'(tx); stepY = STEP_W'(ty); stepZ = STEP_W'(tz);
    delayScale = SCALE_W'(sc); sampleCount = (ABITS+1)'(cnt);
    start = 1;
    while (cyc < 4000 && (doneCyc < 0 || cyc < doneCyc + 30)) begin
      @(negedge clk);
      cyc++;
      start = 0;
      if (poke && cyc == 40) begin
        start = 1;   // R8: ignored while running
        scanX = POS_W'(sx + 50); stepZ = STEP_W'(tz + 7); delayScale = SCALE_W'(sc + 99);
        sampleCount = 0;
      end
      if (backp) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        outReady = LANES'(lfsr) | LANES'(lfsr >> 3);
      end else outReady = '1;
      #1;
      for (int j = 0; j < LANES; j++) begin
        int a = int'(outAddr[j*VB +: VB]);
        int v = int'($signed(outAmp[j*AMP_W +: AMP_W]));
        if (held[j]) begin
          check(outValid[j] && a == lastAddr[j] && v == lastAmp[j],
                {tag, " R5 held result changed"}, a, lastAddr[j]);
          held[j] = 0;
        end
        if (outValid[j] && !outReady[j]) begin
          held[j] = 1; lastAddr[j] = a; lastAmp[j] = v;
        end
        if (outValid[j] && outReady[j]) begin
          got++;
          check(doneCyc < 0, {tag, " R6 result after done"}, a, -1);
          check(a % LANES == j, {tag, " R4 lane residue"}, a % LANES, j);
          check(!seen[a], {tag, " R1 duplicate voxel"}, a, -1);
          seen[a] = 1;
          check(v == expAmp(a), {tag, " R2/R3 amplitude"}, v, expAmp(a));
        end
      end
      if (done) begin
        dones++;
        if (doneCyc < 0) doneCyc = cyc;
      end
    end
    outReady = '1;
    check(got == NVOX, {tag, " R1 voxel count"}, got, NVOX);
    check(dones == 1, {tag, " R6 done pulses"}, dones, 1);
    if (!backp) begin
      check(doneCyc >= NVOX / LANES && doneCyc <= NVOX / LANES + ROOT_W + 8,
            {tag, " R7 start-to-done cycles"}, doneCyc, NVOX / LANES + ROOT_W);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(outValid == '0, "R9 reset outValid", int'(outValid), 0);
    check(done == 1'b0, "R9 reset done", int'(done), 0);
    rst = 0;
    loadSamples(1);
    // all delays in range, unit scale
    doRun("runA", 3, 2, 2, 3, 1, 256, 64, 0, 0);
    // short buffer, fractional scale: many out-of-range voxels (R3)
    loadSamples(2);
    doRun("runB", -3, 10, 5, 4, 6, 300, 20, 0, 0);
    // backpressure plus ignored start and parameter churn (R5, R8)
    loadSamples(3);
    doRun("runC", 20, -7, 3, 3, 3, 200, 64, 1, 1);
    // empty buffer: every amplitude zero (R3 boundary)
    doRun("runD", 0, 0, 1, 1, 1, 256, 0, 0, 0);
    // reset in the middle of a sweep (R9)
    @(negedge clk);
    scanX = 0; scanY = 0; stepX = 1; stepY = 1; stepZ = 1;
    delayScale = 256; sampleCount = 64; start = 1;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    begin
      int leaks = 0;
      for (int c = 0; c < 80; c++) begin
        @(negedge clk);
        #1;
        if (outValid != '0 || done) leaks++;
      end
      check(leaks == 0, "R9 output after mid-run reset", leaks, 0);
    end
    // recovery after reset, negative scan and large scale
    loadSamples(4);
    doRun("runE", -9, -4, 2, 1, 3, 700, 64, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule